// File: doc/BRIEF.md
# Banked External Interrupt Router

The router collects peripheral interrupt lines, grouped in banks of 32 with up to four banks, and sends every line that is pending and enabled to the trigger output of one of several processor threads. Each line is either edge-sensitive or level-sensitive. An edge line latches a captured rising edge in its status bit. A level line's status bit follows the synchronized input. Software reaches the per-bank status, sense and enable words and the per-line routing registers over a plain 32-bit register bus. The bus has a write strobe and a combinational read path.

Writing 1 to a status bit acts on the line as follows. On an edge line it flips the bit, so software can clear a pending edge or raise it again. On a level line it drops the bit for one cycle, so a still-active level produces a fresh rising edge. A routing value of zero leaves the line connected to no thread. Value v in the range 1 to the thread count selects thread v-1. The enable words can be removed by a build parameter, and every line then counts as enabled.

Top module: `irq_router`

## Requirements
- R1: After reset, all status, sense, enable and routing registers read 0 and every trigger output is low.
- R2: The bus address selects the registers as follows.
  - Bank b's status word is at 0x000+8b, its sense word at 0x020+8b and its enable word at 0x040+8b, with bit i belonging to line 32b+i.
  - Line n's routing register is at 0x1000*(1+(n>>5)) + 4*(n&31), and its value sits in bits [2:0].
  - Any other address reads as 0.
- R3: On an edge line (sense bit 0), a rising input edge sets the status bit. An input change driven before clock edge k shows in status after edge k+2.
- R4: On an edge line, writing 1 to a status bit inverts it. Writing 0 leaves it unchanged.
- R5: On a level line (sense bit 1), the status bit follows the synchronized input. Writing 1 to it clears it for one cycle, after which it returns to the input level.
- R6: Trigger output t is high when some line has status 1, enable 1 and routing value t+1. A routing value of 0, or one above the thread count, drives no trigger.
- R7: A line whose enable bit is 0 drives no trigger, and its status is kept.
- R8: Triggers are registered: a trigger follows its lines' status one clock later.
- R9: When a hardware rising edge and a status write of 1 reach the same edge line in the same cycle, the status bit ends at 1.
- R10: With the enable words built out, the enable word reads all ones, writes to it are ignored, and every line can reach its trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NUM_BANKS*32 | Peripheral interrupt lines, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 15 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| trig_out | output | NUM_THREADS | Per-thread trigger, registered, active high |

## Verification
A synchronized rising edge on an edge line can land in the same cycle as a software status write of 1 to that line. The bench provokes this as follows:
- It raises the line two falling edges ahead of the write strobe, so edge capture and the toggle meet at one clock edge.
- The status bit is already set beforehand, so a toggle that won would clear it.

The status is read back right after that edge and must be 1. The random phase keeps input changes and status writes in separate windows, so that the model's order of events stays well defined.

// File: rtl/irq_rt_pkg.sv
// Shared types for the interrupt router.
// Assumes: a bank always holds 32 lines.
package irq_rt_pkg;
    localparam int LINES_PER_BANK = 32;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STAT,
        REG_SENSE,
        REG_EN,
        REG_ROUTE
    } reg_kind_t;
endpackage

// File: rtl/irq_rt_sync.sv
// Two-flop synchronizer with one extra history flop per line.
// It gives the synchronized level and a one-cycle rising-edge pulse.
// Assumes: inputs are asynchronous and held at least two clock periods.
module irq_rt_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] hist_q;

    // Purpose: resample the lines and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~hist_q;
endmodule

// File: rtl/irq_rt_bank.sv
// One bank of 32 lines: the status, sense and enable words.
// Edge lines latch rises and flip on a write of 1; a hardware rise wins over that write.
// Level lines follow the input and drop for one cycle on a write of 1.
// Assumes: write strobes are single-cycle and qualified by the decoder.
module irq_rt_bank #(
    parameter bit HAS_ENABLE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] level,
    input  logic [31:0] rise,
    input  logic        stat_we,
    input  logic        sense_we,
    input  logic        en_we,
    input  logic [31:0] wdata,
    output logic [31:0] status,
    output logic [31:0] sense,
    output logic [31:0] enable
);
    logic [31:0] status_q;
    logic [31:0] sense_q;
    logic [31:0] stat_wr1;
    logic [31:0] status_d;

    assign stat_wr1 = stat_we ? wdata : 32'd0;

    // Purpose: next status per line, according to its sense.
    always_comb begin
        for (int i = 0; i < 32; i++) begin
            if (sense_q[i])
                status_d[i] = level[i] & ~stat_wr1[i];
            else if (rise[i])
                status_d[i] = 1'b1;
            else
                status_d[i] = status_q[i] ^ stat_wr1[i];
        end
    end

    // Purpose: status and sense registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            sense_q  <= '0;
        end else begin
            status_q <= status_d;
            if (sense_we)
                sense_q <= wdata;
        end
    end

    generate
        if (HAS_ENABLE) begin : g_enable
            logic [31:0] en_q;
            // Purpose: software enable word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en_q <= '0;
                else if (en_we)
                    en_q <= wdata;
            end
            assign enable = en_q;
        end else begin : g_no_enable
            logic unused_en;
            assign unused_en = en_we;
            assign enable    = '1;
        end
    endgenerate

    assign status = status_q;
    assign sense  = sense_q;

    // R3 and R9: a captured rise on an edge line leaves the status bit set, even when a write lands in the same cycle.
    p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & ~sense_q) != 32'd0) |=>
            ((status_q & $past(rise & ~sense_q)) == $past(rise & ~sense_q)));

    // R4: without a rise or a write of 1, an edge line's status holds.
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q ^ $past(status_q)) & $past(~sense_q & ~rise & ~stat_wr1)) == 32'd0);

    // R5: a level line that is not written follows the synchronized input.
    p_level_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q ^ $past(level)) & $past(sense_q & ~stat_wr1)) == 32'd0);
endmodule

// File: rtl/irq_rt_route.sv
// Per-line routing registers and the registered per-thread trigger OR.
// Assumes: a routing value v in 1..NUM_THREADS selects thread v-1; any other value selects none.
module irq_rt_route #(
    parameter int NUM_LINES   = 128,
    parameter int NUM_THREADS = 4,
    parameter int RT_W        = 3,
    localparam int IDX_W      = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [RT_W-1:0]        wval,
    output logic [RT_W-1:0]        rval,
    input  logic [NUM_LINES-1:0]   pend,
    output logic [NUM_THREADS-1:0] trig
);
    logic [RT_W-1:0]        route_q [NUM_LINES];
    logic [NUM_THREADS-1:0] trig_d;
    logic [NUM_THREADS-1:0] trig_q;

    // Purpose: routing register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_LINES; n++)
                route_q[n] <= '0;
        end else if (we) begin
            route_q[idx] <= wval;
        end
    end

    assign rval = route_q[idx];

    // Purpose: OR every pending line into the thread it is routed to.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            trig_d[t] = 1'b0;
            for (int n = 0; n < NUM_LINES; n++)
                if (pend[n] && route_q[n] == RT_W'(t + 1))
                    trig_d[t] = 1'b1;
        end
    end

    // Purpose: register the trigger outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= '0;
        else
            trig_q <= trig_d;
    end

    assign trig = trig_q;

    // R6: with nothing pending, no trigger is raised on the next cycle.
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (trig_q == '0));

    // R8: any high trigger has a pending line one cycle earlier.
    p_trig_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q != '0) |-> ($past(pend) != '0));
endmodule

// File: rtl/irq_router.sv
// Top of the banked interrupt router. It decodes the register bus and builds
// one bank block per 32 lines plus a shared routing block.
// Assumes: bus writes are single-cycle strobes; reads are combinational on bus_addr.
module irq_router
    import irq_rt_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int NUM_THREADS = 4,
    parameter bit HAS_ENABLE  = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_BANKS*32-1:0]   irq_in,
    input  logic                      bus_wr,
    input  logic [14:0]               bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [NUM_THREADS-1:0]    trig_out
);
    localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int RT_W      = 3;

    reg_kind_t       kind;
    logic [1:0]      bank_sel;
    logic [4:0]      bit_sel;
    logic [IDX_W-1:0] line_idx;
    logic [RT_W-1:0] route_rd;

    logic [NUM_LINES-1:0] lvl_all;
    logic [NUM_LINES-1:0] rise_all;
    logic [NUM_LINES-1:0] pend_all;
    logic [31:0] stat_b  [NUM_BANKS];
    logic [31:0] sense_b [NUM_BANKS];
    logic [31:0] en_b    [NUM_BANKS];

    // Purpose: decode the register kind, bank and line from the address.
    always_comb begin
        kind     = REG_NONE;
        bank_sel = 2'd0;
        bit_sel  = bus_addr[6:2];
        if (bus_addr[14:12] == 3'd0) begin
            if (bus_addr[11:7] == 5'd0 && bus_addr[2:0] == 3'd0 &&
                int'(bus_addr[4:3]) < NUM_BANKS) begin
                bank_sel = bus_addr[4:3];
                case (bus_addr[6:5])
                    2'd0:    kind = REG_STAT;
                    2'd1:    kind = REG_SENSE;
                    2'd2:    kind = REG_EN;
                    default: kind = REG_NONE;
                endcase
            end
        end else if (int'(bus_addr[14:12]) <= NUM_BANKS &&
                     bus_addr[11:7] == 5'd0 && bus_addr[1:0] == 2'd0) begin
            kind     = REG_ROUTE;
            bank_sel = 2'(bus_addr[14:12] - 3'd1);
        end
    end

    assign line_idx = IDX_W'({bank_sel, bit_sel});

    irq_rt_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .level    (lvl_all),
        .rise     (rise_all)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit = bus_wr && (bank_sel == 2'(b));
            irq_rt_bank #(.HAS_ENABLE(HAS_ENABLE)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .level    (lvl_all[b*32 +: 32]),
                .rise     (rise_all[b*32 +: 32]),
                .stat_we  (hit && kind == REG_STAT),
                .sense_we (hit && kind == REG_SENSE),
                .en_we    (hit && kind == REG_EN),
                .wdata    (bus_wdata),
                .status   (stat_b[b]),
                .sense    (sense_b[b]),
                .enable   (en_b[b])
            );
            assign pend_all[b*32 +: 32] = stat_b[b] & en_b[b];
        end
    endgenerate

    irq_rt_route #(
        .NUM_LINES   (NUM_LINES),
        .NUM_THREADS (NUM_THREADS),
        .RT_W        (RT_W)
    ) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && kind == REG_ROUTE),
        .idx   (line_idx),
        .wval  (bus_wdata[RT_W-1:0]),
        .rval  (route_rd),
        .pend  (pend_all),
        .trig  (trig_out)
    );

    // Purpose: read mux over the bank words and the routing registers.
    always_comb begin
        bus_rdata = 32'd0;
        if (kind == REG_ROUTE) begin
            bus_rdata = 32'(route_rd);
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_sel == 2'(b)) begin
                    case (kind)
                        REG_STAT:  bus_rdata = stat_b[b];
                        REG_SENSE: bus_rdata = sense_b[b];
                        REG_EN:    bus_rdata = en_b[b];
                        default:   bus_rdata = 32'd0;
                    endcase
                end
            end
        end
    end
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] irq_in = '0;
    logic [31:0]  irq_noen = '0;
    logic         bus_wr = 1'b0;
    logic [14:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [31:0]  noen_rdata;
    logic [3:0]   trig_out;
    logic [3:0]   noen_trig;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [127:0] m_stat, m_sense, m_en, m_in;
    logic [2:0]   m_route [128];

    always #5 clk = ~clk;

    irq_router i_irq_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_out(trig_out)
    );

    irq_router #(.NUM_BANKS(1), .NUM_THREADS(4), .HAS_ENABLE(1'b0)) i_irq_router_noen (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_noen), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(noen_rdata),
        .trig_out(noen_trig)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd_noen(input logic [14:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = noen_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [14:0] route_addr(input int n);
        return 15'(32'h1000 * (1 + (n >> 5)) + 4 * (n & 31));
    endfunction

    function automatic logic [3:0] exp_trig();
        logic [3:0] t = '0;
        for (int n = 0; n < 128; n++)
            if (m_stat[n] && m_en[n] && m_route[n] >= 3'd1 && m_route[n] <= 3'd4)
                t[m_route[n] - 3'd1] = 1'b1;
        return t;
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int b = 0; b < 4; b++) begin
            rd(15'(8 * b), d);          chk("R1 status", d, 0);
            rd(15'(32'h20 + 8 * b), d); chk("R1 sense", d, 0);
            rd(15'(32'h40 + 8 * b), d); chk("R1 enable", d, 0);
        end
        rd(route_addr(37), d); chk("R1 route", d, 0);
        chk("R1 trig", 32'(trig_out), 0);

        // R2: register map and unmapped reads
        wr(route_addr(37), 32'd3);
        wr(15'h048, 32'hFFFF_FFFF);
        rd(route_addr(37), d); chk("R2 route readback", d, 3);
        rd(15'h048, d);        chk("R2 enable readback", d, 32'hFFFF_FFFF);
        rd(15'h068, d);        chk("R2 unmapped kind", d, 0);
        rd(15'h2094, d);       chk("R2 route alias", d, 0);
        rd(15'h5014, d);       chk("R2 bank beyond range", d, 0);

        // R3, R8: exact capture latency on line 37 (bank 1 bit 5)
        @(negedge clk); irq_in[37] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(15'h008, d); chk("R3 status before edge k+2", d, 0);
        @(negedge clk);
        rd(15'h008, d); chk("R3 status after edge k+2", d, 32'h20);
        chk("R8 trig not yet", 32'(trig_out), 0);
        @(negedge clk);
        chk("R8 trig one cycle later", 32'(trig_out), 32'h4);
        chk("R6 routing value 3 to thread 2", 32'(trig_out), 32'h4);

        // R4: write 0 no effect, write 1 toggles
        wr(15'h008, 32'd0);
        rd(15'h008, d); chk("R4 write 0 holds", d, 32'h20);
        wr(15'h008, 32'h20);
        rd(15'h008, d); chk("R4 toggle clears", d, 0);
        settle(); chk("R4 trig dropped", 32'(trig_out), 0);
        wr(15'h008, 32'h20);
        rd(15'h008, d); chk("R4 toggle raises", d, 32'h20);
        settle(); chk("R4 trig re-raised", 32'(trig_out), 32'h4);

        // R7: enable gating
        wr(15'h048, ~32'h20);
        settle(); chk("R7 disabled line silent", 32'(trig_out), 0);
        rd(15'h008, d); chk("R7 status kept", d, 32'h20);
        wr(15'h048, 32'hFFFF_FFFF);

        // R6: route 0 and out-of-range values reach no thread
        wr(route_addr(37), 32'd0); settle();
        chk("R6 route zero", 32'(trig_out), 0);
        wr(route_addr(37), 32'd7); settle();
        chk("R6 route above thread count", 32'(trig_out), 0);
        wr(route_addr(37), 32'd1); settle();
        chk("R6 route to thread 0", 32'(trig_out), 32'h1);

        // R9: hardware rise and software write of 1 in the same cycle
        irq_in[37] = 1'b0; settle();
        rd(15'h008, d); chk("R4 falling input holds", d, 32'h20);
        @(negedge clk); irq_in[37] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = 15'h008; bus_wdata = 32'h20; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(15'h008, d); chk("R9 hardware set wins", d, 32'h20);

        // R5: level line 70 (bank 2 bit 6) with retrigger
        wr(15'h050, 32'h40);
        wr(15'h030, 32'h40);
        wr(route_addr(70), 32'd4);
        irq_in[70] = 1'b1; settle();
        rd(15'h010, d); chk("R5 level status", d, 32'h40);
        chk("R5 level trig", 32'(trig_out[3]), 1);
        wr(15'h010, 32'h40);
        rd(15'h010, d); chk("R5 retrigger drops", d, 0);
        @(negedge clk);
        rd(15'h010, d); chk("R5 retrigger returns", d, 32'h40);
        chk("R5 trig low during retrigger", 32'(trig_out[3]), 0);
        @(negedge clk);
        chk("R5 trig re-raised", 32'(trig_out[3]), 1);
        irq_in[70] = 1'b0; settle();
        rd(15'h010, d); chk("R5 level follows low", d, 0);

        // Random phase from a fresh reset
        @(negedge clk); rst_n = 1'b0; irq_in = '0;
        repeat (4) @(negedge clk); rst_n = 1'b1;
        m_stat = '0; m_sense = '0; m_en = '0; m_in = '0;
        for (int n = 0; n < 128; n++) m_route[n] = '0;
        for (int it = 0; it < 300; it++) begin
            int b;
            logic [31:0] v;
            b = int'($urandom % 4);
            v = $urandom;
            case ($urandom % 5)
                0: begin
                    wr(15'(32'h20 + 8 * b), v);
                    for (int i = 0; i < 32; i++) begin
                        m_sense[b*32+i] = v[i];
                        if (v[i]) m_stat[b*32+i] = m_in[b*32+i];
                    end
                end
                1: begin
                    v = v | $urandom;
                    wr(15'(32'h40 + 8 * b), v);
                    m_en[b*32 +: 32] = v;
                end
                2: begin
                    int n;
                    n = int'($urandom % 128);
                    m_route[n] = 3'($urandom % 8);
                    wr(route_addr(n), 32'(m_route[n]));
                end
                3: begin
                    logic [127:0] tm;
                    tm = {$urandom & $urandom, $urandom & $urandom,
                          $urandom & $urandom, $urandom & $urandom};
                    for (int n = 0; n < 128; n++) begin
                        logic nv;
                        nv = m_in[n] ^ tm[n];
                        if (m_sense[n]) m_stat[n] = nv;
                        else if (nv && !m_in[n]) m_stat[n] = 1'b1;
                        m_in[n] = nv;
                    end
                    @(negedge clk); irq_in = m_in;
                end
                default: begin
                    wr(15'(8 * b), v);
                    for (int i = 0; i < 32; i++) begin
                        if (m_sense[b*32+i]) m_stat[b*32+i] = m_in[b*32+i];
                        else m_stat[b*32+i] = m_stat[b*32+i] ^ v[i];
                    end
                end
            endcase
            settle();
            chk("R6 random trig", 32'(trig_out), 32'(exp_trig()));
            b = int'($urandom % 4);
            rd(15'(8 * b), d); chk("R3 R4 R5 random status", d, m_stat[b*32 +: 32]);
        end

        // R10: enable words built out
        wr(15'h020, 32'd0);
        rd_noen(15'h000, d);
        wr(15'h000, d);
        for (int i = 0; i < 32; i++) wr(15'(32'h1000 + 4 * i), 32'd0);
        wr(15'h040, 32'd0);
        rd_noen(15'h040, d); chk("R10 enable reads ones", d, 32'hFFFF_FFFF);
        rd_noen(15'h000, d); chk("R10 status cleared", d, 0);
        settle(); chk("R10 trig idle", 32'(noen_trig), 0);
        wr(15'h1000, 32'd1);
        irq_noen[0] = 1'b1; settle();
        chk("R10 line reaches trigger", 32'(noen_trig), 32'h1);

        done = 1'b1;
        report();
        $finish;
    end
endmodule